// File: doc/BRIEF.md
# Open-Load and Thermal Error Qualifier

This block watches a bank of constant-current output channels and decides when to report a fault. Each channel supplies an "on" enable and a "low voltage" indication from an external comparator. An open load on a channel counts only when the channel has been driven on for long enough to settle and the comparator still reports a low output voltage. A thermal flag is reported directly. The combined fault drives an active-low, wired-OR error line, which is modelled here as an output enable: when it is high, the line is pulled to ground.

Channels switch on in a staggered sequence, so each channel's settle window grows with its index. A blank input masks every open-load result but never the thermal flag. A latch strobe takes a snapshot of the qualified open-load flags into a status vector on its falling edge, and the vector then holds until the next falling edge.

Top module: `errq_monitor`

## Requirements
- R1: `err_oe` is 1 in the cycle after `therm_flag` is sampled 1, whatever the values of `blank` and the channels. When `therm_flag` clears and no qualified open-load flag is present, `err_oe` returns to 0 one cycle later, so the thermal fault is not latched.
- R2: Channel n counts as settled only after `chan_on[n]` has been sampled 1 on SETTLE_CYC + n*STAGGER_CYC consecutive rising edges. Before that, its low indication does not affect `err_oe` or `open_status`.
- R3: Sampling `chan_on[n]` as 0 on any edge restarts channel n's settle count from zero.
- R4: A settled, on channel raises a qualified open-load flag only while `chan_low[n]` is 1. When no flag is qualified and the thermal flag is 0, `err_oe` is 0 one cycle later.
- R5: While `blank` is 1, all open-load flags are masked. Only the thermal flag can then set `err_oe`, and a blanked capture stores zeros.
- R6: When `xlat` is sampled 0 on the edge after it was sampled 1, `open_status[n]` takes the qualified open-load flag of channel n as it stood before that edge. Bit n belongs to channel n.
- R7: `open_status` keeps its value on every other edge, including while `xlat` stays high.
- R8: A synchronous active-high `rst` clears `err_oe`, `open_status` and all settle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_on | input | NCH | Per-channel output-on enables |
| chan_low | input | NCH | Per-channel low-output-voltage indications |
| therm_flag | input | 1 | Over-temperature flag |
| blank | input | 1 | Masks open-load reporting when 1 |
| xlat | input | 1 | Latch strobe; the falling edge captures the status |
| err_oe | output | 1 | 1 = pull the shared error line low |
| open_status | output | NCH | Captured qualified open-load flags |

## Verification
The assertions assume that the inputs are synchronous to `clk` and stable across each rising edge, and that reset is asserted from time zero. The bench drives every input on the falling edge, so each one holds for a full cycle before it is sampled. The stimulus keeps channels on for stretches longer than the longest stagger window, so that late channels do settle. Strobe pulses last one or more cycles, and the random phase changes only one channel enable every few cycles, so that settle counts both complete and restart.

// File: rtl/errq_pkg.sv
package errq_pkg;

    // Capture tracking for the strobe
    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_e;

    // Per-channel observation bundle
    typedef struct packed {
        logic on;
        logic low;
        logic settled;
    } chan_obs_t;

    // Settle length for channel ch: base plus ch stagger steps
    function automatic int unsigned settle_limit(input int unsigned ch,
                                                 input int unsigned base,
                                                 input int unsigned step);
        return base + ch * step;
    endfunction

    // Bits needed to hold values 0..v
    function automatic int unsigned bits_for(input int unsigned v);
        int unsigned n;
        n = 1;
        while ((1 << n) <= v) n++;
        return n;
    endfunction

    // Qualify one channel's open-load flag
    function automatic logic qualify(input chan_obs_t o, input logic mask);
        return o.on & o.settled & o.low & ~mask;
    endfunction

endpackage

// File: rtl/errq_settle.sv
module errq_settle #(
    parameter int unsigned LIMIT = 6,
    parameter int unsigned CW    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic on,
    output logic settled
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !on) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign settled = (cnt == LIM);

    // R3: an off sample restarts the count
    a_r3_off_restarts: assert property (@(posedge clk) disable iff (rst)
        !on |=> (cnt == '0));

    // R2: settling only ever follows an on sample
    a_r2_settle_after_on: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> $past(on));

    // R2: count never passes its limit
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (cnt == LIM) |=> (cnt == LIM) || (cnt == '0));

endmodule

// File: rtl/errq_capture.sv
module errq_capture
    import errq_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           xlat,
    input  logic [NCH-1:0] qual,
    output logic [NCH-1:0] status
);
    stb_state_e stb_q;
    logic       fall;

    assign fall = (stb_q == STB_HIGH) && !xlat;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= STB_LOW;
            status <= '0;
        end else begin
            stb_q <= xlat ? STB_HIGH : STB_LOW;
            if (fall) begin
                status <= qual;
            end
        end
    end

    // R6: falling strobe takes the qualified vector
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        ($past(xlat) && !xlat) |=> (status == $past(qual)));

    // R7: status holds on every other edge
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !($past(xlat) && !xlat) |=> $stable(status));

endmodule

// File: rtl/errq_monitor.sv
module errq_monitor
    import errq_pkg::*;
#(
    parameter int unsigned NCH         = 16,
    parameter int unsigned SETTLE_CYC  = 6,
    parameter int unsigned STAGGER_CYC = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] chan_on,
    input  logic [NCH-1:0] chan_low,
    input  logic           therm_flag,
    input  logic           blank,
    input  logic           xlat,
    output logic           err_oe,
    output logic [NCH-1:0] open_status
);
    localparam int unsigned MAX_LIM = SETTLE_CYC + (NCH - 1) * STAGGER_CYC;
    localparam int unsigned CW      = bits_for(MAX_LIM);

    logic [NCH-1:0] settled;
    logic [NCH-1:0] qual;
    logic           err_d;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_obs_t obs;

        errq_settle #(
            .LIMIT (settle_limit(ch, SETTLE_CYC, STAGGER_CYC)),
            .CW    (CW)
        ) u_settle (
            .clk     (clk),
            .rst     (rst),
            .on      (chan_on[ch]),
            .settled (settled[ch])
        );

        always_comb begin
            obs.on      = chan_on[ch];
            obs.low     = chan_low[ch];
            obs.settled = settled[ch];
            qual[ch]    = qualify(obs, blank);
        end
    end

    assign err_d = therm_flag | (|qual);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_oe <= 1'b0;
        end else begin
            err_oe <= err_d;
        end
    end

    errq_capture #(
        .NCH (NCH)
    ) u_capture (
        .clk    (clk),
        .rst    (rst),
        .xlat   (xlat),
        .qual   (qual),
        .status (open_status)
    );

    // R1: thermal flag always reaches the error line
    a_r1_thermal: assert property (@(posedge clk) disable iff (rst)
        therm_flag |=> err_oe);

    // R5: with blank and no thermal flag the line is released
    a_r5_blank_masks: assert property (@(posedge clk) disable iff (rst)
        (blank && !therm_flag) |=> !err_oe);

    // R4: no low indication and no thermal flag gives no error
    a_r4_needs_low: assert property (@(posedge clk) disable iff (rst)
        ((chan_low == '0) && !therm_flag) |=> !err_oe);

    // R2: nothing off contributes
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        ((chan_on == '0) && !therm_flag) |=> !err_oe);

endmodule

// File: tb/errq_monitor_tb.sv
module errq_monitor_tb;
    localparam int NCH = 16;
    localparam int SET = 6;
    localparam int STG = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] chan_on = '0;
    logic [NCH-1:0] chan_low = '0;
    logic           therm_flag = 1'b0;
    logic           blank = 1'b0;
    logic           xlat = 1'b0;
    logic           err_oe;
    logic [NCH-1:0] open_status;

    int    tests = 0;
    int    fails = 0;
    string tag = "R8";
    bit    started = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    errq_monitor #(.NCH(NCH), .SETTLE_CYC(SET), .STAGGER_CYC(STG)) u_dut (
        .clk(clk), .rst(rst), .chan_on(chan_on), .chan_low(chan_low),
        .therm_flag(therm_flag), .blank(blank), .xlat(xlat),
        .err_oe(err_oe), .open_status(open_status)
    );

    // Behavioural reference model
    int             ontime [NCH];
    logic           m_err;
    logic [NCH-1:0] m_stat;
    logic           m_xprev;

    always @(posedge clk) begin
        logic [NCH-1:0] q;
        started <= 1;
        if (rst) begin
            for (int i = 0; i < NCH; i++) ontime[i] <= 0;
            m_err   <= 0;
            m_stat  <= '0;
            m_xprev <= 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                q[i] = chan_on[i] && (ontime[i] >= SET + i * STG) && chan_low[i] && !blank;
                ontime[i] <= chan_on[i] ? ontime[i] + 1 : 0;
            end
            m_err <= therm_flag || (q != '0);
            if (m_xprev && !xlat) m_stat <= q;
            m_xprev <= xlat;
        end
    end

    task automatic check(input string t, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // Per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            check({tag, " err_oe"}, {{(NCH-1){1'b0}}, err_oe}, {{(NCH-1){1'b0}}, m_err});
            check({tag, " open_status"}, open_status, m_stat);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_xlat(input int w);
        xlat = 1; cyc(w); xlat = 0; cyc(2);
    endtask

    initial begin
        logic [31:0] lf;
        cyc(3);
        tag = "R8";
        check("R8 reset err_oe", {{(NCH-1){1'b0}}, err_oe}, '0);
        check("R8 reset status", open_status, '0);
        rst = 0;
        cyc(2);

        // Thermal flag with and without blank
        tag = "R1";
        therm_flag = 1; blank = 1; cyc(3);
        check("R1 thermal under blank", {{(NCH-1){1'b0}}, err_oe}, 1);
        blank = 0; cyc(2);
        therm_flag = 0; cyc(1);
        check("R1 not latched", {{(NCH-1){1'b0}}, err_oe}, 0);

        // Staggered settling: channel 15 alone needs SET+15*STG cycles
        tag = "R2";
        chan_low = '1;
        chan_on = 16'h8000; cyc(SET + 15 * STG);
        check("R2 ch15 not yet settled", {{(NCH-1){1'b0}}, err_oe}, 0);
        cyc(2);
        check("R2 ch15 settled", {{(NCH-1){1'b0}}, err_oe}, 1);
        chan_on = '1; cyc(50);

        // Restart on off
        tag = "R3";
        chan_on = 16'h0001; cyc(SET + 2);
        chan_on = 16'h0000; cyc(1);
        chan_on = 16'h0001; cyc(SET - 1);
        check("R3 restarted count", {{(NCH-1){1'b0}}, err_oe}, 0);
        cyc(3);

        // Low indication needed
        tag = "R4";
        chan_on = '1; cyc(40);
        chan_low = 16'h0000; cyc(2);
        check("R4 no low no error", {{(NCH-1){1'b0}}, err_oe}, 0);
        chan_low = 16'h0420; cyc(3);

        // Capture and hold
        tag = "R6";
        pulse_xlat(1);
        check("R6 captured pattern", open_status, 16'h0420);
        tag = "R7";
        chan_low = 16'h8001; xlat = 1; cyc(4);
        check("R7 hold while strobe high", open_status, 16'h0420);
        xlat = 0; cyc(2);
        tag = "R6";
        check("R6 second capture", open_status, 16'h8001);

        // Blank masking
        tag = "R5";
        blank = 1; cyc(2);
        check("R5 blank releases line", {{(NCH-1){1'b0}}, err_oe}, 0);
        pulse_xlat(2);
        check("R5 blanked capture zero", open_status, 16'h0000);
        blank = 0; cyc(3);

        // Mixed pseudo-random stretch
        tag = "R2/R3/R6 mix";
        lf = 32'hACE1_2357;
        for (int k = 0; k < 1500; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (k % 6 == 0) chan_on[lf[3:0]] = ~chan_on[lf[3:0]];
            chan_low[lf[7:4]] = lf[8];
            blank = (lf[15:11] == 0);
            therm_flag = (lf[20:16] == 0);
            xlat = (lf[23:21] == 0);
            cyc(1);
        end
        cyc(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        fails++;
        tests++;
        done = 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule